// File: doc/BRIEF.md
# CSR Bus Width Down-Converter

This block sits between a wide register port on the processor side and a narrow control/status register bus. The processor word is `RATIO` times as wide as the bus. Each processor read or write is accepted through a request/acknowledge handshake. The block turns it into a run of `RATIO` back-to-back single-cycle bus accesses. These accesses use consecutive bus addresses, lowest chunk first. The block slices the write word into bus-sized pieces. For a read, it collects the returned pieces into one wide word. Because the highest chunk is always accessed last, a chunked register behind the bus captures its value on the first access of a run and commits on the final one.

A small state machine orders the work. Its states are `ST_IDLE` (waiting), `ST_ISSUE` (one strobe per cycle, chunk index counting up), `ST_DRAIN` (reads only: waits one cycle for the last returned piece) and `ST_ACK` (one-cycle acknowledge). The transitions are:
- IDLE→ISSUE when a request is sampled.
- ISSUE→ISSUE while chunks remain.
- ISSUE→ACK after the last write chunk.
- ISSUE→DRAIN after the last read chunk.
- DRAIN→ACK.
- ACK→IDLE.

Only one transaction is in flight at a time.

Top module: `csr_wide_bridge`

## Requirements
- R1: While reset (synchronous, active high) is held and in the cycle after it, no strobe is driven and `cpu_ack` and `cpu_busy` are low.
- R2: Every accepted request produces exactly `RATIO` bus accesses, all reads when `cpu_we` was 0 at acceptance, all writes when it was 1; the two strobes are never high together.
- R3: Sub-access i (i = 0 upward) drives `csr_addr` = `cpu_addr`*`RATIO` + i, valid in the same cycle as its strobe, so addresses ascend by one per cycle.
- R4: On write sub-access i, `csr_wdata` equals bits [i*BUS_DW +: BUS_DW] of the accepted write word.
- R5: Data returned on `csr_rdata` in the cycle after read sub-access i lands in bits [i*BUS_DW +: BUS_DW] of `cpu_rdata`; zero returned for an unmapped address appears as zero.
- R6: For a write, `cpu_ack` is high for exactly one cycle, the cycle after the last write strobe.
- R7: For a read, `cpu_ack` is high for exactly one cycle, two cycles after the last read strobe (the cycle after the last piece is captured), with `cpu_rdata` complete in that cycle.
- R8: `cpu_busy` is high from the cycle after acceptance through the acknowledge cycle; requests, address, data and direction presented while busy are ignored.
- R9: With `RATIO` = 1 a write gives one strobe and acknowledges the next cycle, and a read gives one strobe and acknowledges two cycles later.
- R10: No strobe is driven while `cpu_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, sampled only while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | CPU_AW | Processor word address |
| cpu_wdata | input | BUS_DW*RATIO | Wide write word |
| cpu_rdata | output | BUS_DW*RATIO | Assembled read word, valid with acknowledge |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Transaction in progress |
| csr_addr | output | CPU_AW+log2(RATIO) | Bus address |
| csr_rd_stb | output | 1 | Bus read strobe |
| csr_wr_stb | output | 1 | Bus write strobe |
| csr_wdata | output | BUS_DW | Bus write chunk |
| csr_rdata | input | BUS_DW | Bus read data, one cycle after read strobe |

## Verification
The bench sweeps every word address of a four-chunk configuration with writes and then reads. It targets several corner cases:
- A design that reversed the chunk order, skipped a chunk or issued one strobe too many shows up in the logged address run. It also breaks the commit of a 24-bit register that updates only on the fourth write.
- An off-by-one acknowledge fires on a read before the final piece arrives, and the top byte is then stale.
- Unmapped words must read back as zero.
- Requests changed mid-transaction must not disturb the latched address, data or direction.
- A one-chunk instance checks that the degenerate ratio keeps the same latency.

// File: rtl/csr_wb_pkg.sv
package csr_wb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_ACK   = 2'd3
    } wb_state_t;
endpackage

// File: rtl/csr_wb_seq.sv
module csr_wb_seq
    import csr_wb_pkg::*;
#(
    parameter int CPU_AW = 4,
    parameter int RATIO  = 4,
    localparam int IDX_W  = (RATIO > 1) ? $clog2(RATIO) : 1,
    localparam int CSR_AW = CPU_AW + $clog2(RATIO)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [CPU_AW-1:0] addr,
    output logic              accept,
    output logic [IDX_W-1:0]  idx,
    output logic [CSR_AW-1:0] csr_addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              ack,
    output logic              busy
);
    wb_state_t         state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [CPU_AW-1:0] word_q;
    logic              we_q;
    logic              last_chunk;

    assign last_chunk = (idx_q == IDX_W'(RATIO - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (req) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (last_chunk) begin
                    idx_d   = '0;
                    state_d = we_q ? ST_ACK : ST_DRAIN;
                end else begin
                    idx_d = idx_q + IDX_W'(1);
                end
            end
            ST_DRAIN: state_d = ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            word_q  <= '0;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (accept) begin
                word_q <= addr;
                we_q   <= we;
            end
        end
    end

    // outputs
    always_comb begin
        accept = (state_q == ST_IDLE) && req;
        rd_stb = (state_q == ST_ISSUE) && !we_q;
        wr_stb = (state_q == ST_ISSUE) &&  we_q;
        ack    = (state_q == ST_ACK);
        busy   = (state_q != ST_IDLE);
        idx    = idx_q;
    end

    generate
        if (RATIO == 1) begin : g_flat
            assign csr_addr = word_q;
        end else begin : g_chunked
            assign csr_addr = {word_q, idx_q};
        end
    endgenerate

    p_one_dir_r2: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        ((rd_stb || wr_stb) && $past(rd_stb || wr_stb)) |->
            (csr_addr == $past(csr_addr) + CSR_AW'(1)));
    p_first_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_stb || wr_stb) |-> (idx == '0));
    p_ack_after_wr_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_stb) |-> ack);
    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(rd_stb || wr_stb));
endmodule

// File: rtl/csr_wb_wslice.sv
module csr_wb_wslice #(
    parameter int BUS_DW = 8,
    parameter int RATIO  = 4,
    localparam int IDX_W  = (RATIO > 1) ? $clog2(RATIO) : 1,
    localparam int CPU_DW = BUS_DW * RATIO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [CPU_DW-1:0] wide_in,
    input  logic [IDX_W-1:0]  idx,
    output logic [BUS_DW-1:0] chunk_out
);
    logic [CPU_DW-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)         word_q <= '0;
        else if (accept) word_q <= wide_in;
    end

    assign chunk_out = word_q[idx * BUS_DW +: BUS_DW];

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(accept) |-> $stable(word_q));
endmodule

// File: rtl/csr_wb_rasm.sv
module csr_wb_rasm #(
    parameter int BUS_DW = 8,
    parameter int RATIO  = 4,
    localparam int IDX_W  = (RATIO > 1) ? $clog2(RATIO) : 1,
    localparam int CPU_DW = BUS_DW * RATIO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BUS_DW-1:0] bus_in,
    output logic [CPU_DW-1:0] wide_out
);
    logic             cap_q;
    logic [IDX_W-1:0] cap_idx_q;

    // bus data returns one cycle after the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q     <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_q     <= rd_stb;
            cap_idx_q <= idx;
        end
    end

    generate
        for (genvar g = 0; g < RATIO; g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)
                    wide_out[g*BUS_DW +: BUS_DW] <= '0;
                else if (cap_q && cap_idx_q == IDX_W'(g))
                    wide_out[g*BUS_DW +: BUS_DW] <= bus_in;
            end
        end
    endgenerate

    p_cap_follows_r5: assert property (@(posedge clk) disable iff (rst)
        cap_q |-> $past(rd_stb));
endmodule

// File: rtl/csr_wide_bridge.sv
module csr_wide_bridge #(
    parameter int CPU_AW = 4,
    parameter int BUS_DW = 8,
    parameter int RATIO  = 4,
    localparam int IDX_W  = (RATIO > 1) ? $clog2(RATIO) : 1,
    localparam int CPU_DW = BUS_DW * RATIO,
    localparam int CSR_AW = CPU_AW + $clog2(RATIO)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_busy,
    output logic [CSR_AW-1:0] csr_addr,
    output logic              csr_rd_stb,
    output logic              csr_wr_stb,
    output logic [BUS_DW-1:0] csr_wdata,
    input  logic [BUS_DW-1:0] csr_rdata
);
    logic             accept;
    logic [IDX_W-1:0] idx;

    csr_wb_seq #(.CPU_AW(CPU_AW), .RATIO(RATIO)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (cpu_req),
        .we       (cpu_we),
        .addr     (cpu_addr),
        .accept   (accept),
        .idx      (idx),
        .csr_addr (csr_addr),
        .rd_stb   (csr_rd_stb),
        .wr_stb   (csr_wr_stb),
        .ack      (cpu_ack),
        .busy     (cpu_busy)
    );

    csr_wb_wslice #(.BUS_DW(BUS_DW), .RATIO(RATIO)) u_wsl (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .wide_in   (cpu_wdata),
        .idx       (idx),
        .chunk_out (csr_wdata)
    );

    csr_wb_rasm #(.BUS_DW(BUS_DW), .RATIO(RATIO)) u_ras (
        .clk      (clk),
        .rst      (rst),
        .rd_stb   (csr_rd_stb),
        .idx      (idx),
        .bus_in   (csr_rdata),
        .wide_out (cpu_rdata)
    );

    p_busy_on_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_busy) |=> cpu_busy);
    p_ack_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> cpu_busy);
    p_rd_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && !$past(csr_wr_stb)) |-> $past(csr_rd_stb, 2));
endmodule

// File: tb/sim_csr_wide_bridge.sv
`timescale 1ns/1ps
module sim_csr_wide_bridge;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // main instance: 8-bit bus, ratio 4, 16 words
    logic        req = 0, we_i = 0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack, busy, rd, wr;
    logic [5:0]  caddr;
    logic [7:0]  cwdata;
    logic [7:0]  crdata;

    csr_wide_bridge #(.CPU_AW(4), .BUS_DW(8), .RATIO(4)) u0 (
        .clk(clk), .rst(rst), .cpu_req(req), .cpu_we(we_i), .cpu_addr(addr),
        .cpu_wdata(wdata), .cpu_rdata(rdata), .cpu_ack(ack), .cpu_busy(busy),
        .csr_addr(caddr), .csr_rd_stb(rd), .csr_wr_stb(wr),
        .csr_wdata(cwdata), .csr_rdata(crdata));

    // bus-side model: addresses >= 56 are unmapped and read zero
    logic [7:0]  mem [64];
    logic [23:0] reg24;
    int          commits;
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
            crdata  <= 8'h00;
            reg24   <= '0;
            commits <= 0;
        end else begin
            if (wr && caddr < 6'd56) mem[caddr] <= cwdata;
            if (wr && caddr == 6'd15) begin
                reg24   <= {mem[14], mem[13], mem[12]};
                commits <= commits + 1;
            end
            crdata <= (rd && caddr < 6'd56) ? mem[caddr] : 8'h00;
        end
    end

    // ratio-1 instance
    logic       req1 = 0, we1 = 0;
    logic [3:0] addr1 = '0;
    logic [7:0] wdata1 = '0, rdata1, cwdata1, crdata1;
    logic       ack1, busy1, rd1, wr1;
    logic [3:0] caddr1;

    csr_wide_bridge #(.CPU_AW(4), .BUS_DW(8), .RATIO(1)) u1 (
        .clk(clk), .rst(rst), .cpu_req(req1), .cpu_we(we1), .cpu_addr(addr1),
        .cpu_wdata(wdata1), .cpu_rdata(rdata1), .cpu_ack(ack1), .cpu_busy(busy1),
        .csr_addr(caddr1), .csr_rd_stb(rd1), .csr_wr_stb(wr1),
        .csr_wdata(cwdata1), .csr_rdata(crdata1));

    always @(posedge clk) crdata1 <= rd1 ? 8'(caddr1 * 7 + 3) : 8'h00;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'h9E37_79B9 * (a + 1) ^ 32'h0F0F_3C3C;
    endfunction

    task automatic xact(input bit w, input logic [3:0] a, input logic [31:0] wd,
                        input bit intrude, output logic [31:0] rv);
        int n = 0;
        int c = 0;
        bit got = 0;
        @(negedge clk);
        req = 1; we_i = w; addr = a; wdata = wd;
        while (!got && c < 20) begin
            @(negedge clk);
            c++;
            if (intrude) begin addr = ~a; wdata = ~wd; we_i = !w; end
            else req = 0;
            if (rd || wr) begin
                chk(wr == w && rd == !w, "R2 direction", {wr, rd}, {w, !w});
                chk(caddr == 6'(a * 4 + n), "R3 address", caddr, 6'(a * 4 + n));
                if (w) chk(cwdata == wd[n*8 +: 8], "R4 chunk", cwdata, wd[n*8 +: 8]);
                n++;
            end
            if (!busy) chk(0, "R8 busy during transaction", busy, 1);
            if (ack) got = 1;
        end
        req = 0;
        chk(n == 4, "R2 access count", n, 4);
        if (w) chk(c == 5, "R6 write ack cycle", c, 5);
        else   chk(c == 6, "R7 read ack cycle", c, 6);
        rv = rdata;
        @(negedge clk);
        chk(!ack && !busy && !rd && !wr, "R8 R10 idle after ack",
            {ack, busy, rd, wr}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int c1;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!ack && !busy && !rd && !wr, "R1 reset outputs", {ack, busy, rd, wr}, 0);
        rst = 0;
        @(negedge clk);
        chk(!ack && !busy && !rd && !wr && !ack1 && !busy1, "R1 after reset",
            {ack, busy, rd, wr}, 0);

        // write sweep over every word
        for (int a = 0; a < 16; a++) xact(1, 4'(a), pat(a), 0, rv);
        chk(commits == 1, "R6 24-bit register commit count", commits, 1);
        chk(reg24 == pat(3)[23:0], "R4 24-bit register value", reg24, pat(3)[23:0]);

        // read sweep; words 14 and 15 are unmapped
        for (int a = 0; a < 16; a++) begin
            xact(0, 4'(a), 32'h0, 0, rv);
            chk(rv == ((a < 14) ? pat(a) : 32'h0), "R5 read assembly", rv,
                (a < 14) ? pat(a) : 32'h0);
        end

        // R8: inputs changed while busy are ignored
        xact(1, 4'd6, 32'hA5C3_0F81, 1, rv);
        xact(0, 4'd6, 32'h0, 1, rv);
        chk(rv == 32'hA5C3_0F81, "R8 intrusion ignored", rv, 32'hA5C3_0F81);

        // R9: ratio one, write
        @(negedge clk); req1 = 1; we1 = 1; addr1 = 4'd5; wdata1 = 8'hC3;
        @(negedge clk); req1 = 0;
        chk(wr1 && !rd1 && caddr1 == 4'd5 && cwdata1 == 8'hC3, "R9 single write strobe",
            {wr1, rd1, caddr1, cwdata1}, {1'b1, 1'b0, 4'd5, 8'hC3});
        @(negedge clk);
        chk(ack1 && !wr1, "R9 write ack next cycle", ack1, 1);
        // R9: ratio one, read
        @(negedge clk); req1 = 1; we1 = 0; addr1 = 4'd5;
        c1 = 0;
        @(negedge clk); req1 = 0;
        chk(rd1 && caddr1 == 4'd5, "R9 single read strobe", {rd1, caddr1}, {1'b1, 4'd5});
        @(negedge clk);
        chk(!ack1 && !rd1, "R9 no early ack", ack1, 0);
        @(negedge clk);
        chk(ack1 && rdata1 == 8'd38, "R9 read ack and data", {ack1, rdata1}, {1'b1, 8'd38});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule